// File: doc/BRIEF.md
# Snooping MESI Line State Controller

This block keeps the coherence state of every line of one processor's cache in a bus-based multiprocessor that uses invalidation-based Modified/Exclusive/Shared/Invalid coherence. It holds a small direct-mapped array of tags and states, answers the local processor's read and write requests, and raises bus transactions when a request cannot complete locally. Data storage, bus arbitration and memory are outside the block. The bus is atomic and carries one transaction at a time: the block raises a request, and an outside arbiter grants it in the cycle it completes.

At the same time the block watches transactions that other caches place on the bus. A snooped read that hits a valid line asserts the shared response. The requester uses that response to choose between Shared and Exclusive on a fill. When the snooped line is dirty, the block also signals that it will supply or write back the data. A snooped intent-to-write removes the local copy. A write that hits a clean-exclusive line upgrades to Modified without any bus traffic.

Top module: `mesi_line_ctrl`

## Requirements
- R1: After reset every line is Invalid, so `cpu_line_state` reads 0 for any address. The state encoding is I=0, S=1, E=2, M=3.
- R2: A local read miss issues a read (kind 0). In the granted cycle the read acknowledges, and the line fills as Shared if `bus_shared_in` is high, or as Exclusive otherwise.
- R3: A local write to a line held in E or M completes in the same cycle with no bus request, and the line is M afterwards. A local read that hits in any valid state completes with no bus request.
- R4: A local write miss issues an intent-to-write (kind 1). In the granted cycle the write acknowledges, and the line becomes M.
- R5: A local write to a Shared line issues intent-to-write first and becomes M only once it is granted.
- R6: A snooped read that hits a Modified line asserts both `snp_wb` and `snp_shared`, and the line becomes Shared.
- R7: A snooped read that hits an Exclusive line makes it Shared. A snooped read that hits a Shared line leaves it Shared. Both cases assert `snp_shared`.
- R8: A snooped intent-to-write that hits a valid line makes it Invalid and asserts `snp_shared`. It also asserts `snp_wb` if the line was Modified.
- R9: A snoop whose index equals the index of the pending local request takes priority. The local request is not acknowledged in that cycle and retries afterwards.
- R10: A miss on an index whose line is Modified under another tag first issues a write-back (kind 2) carrying the victim's address. The victim becomes Invalid on grant, and the miss then proceeds.
- R11: Across caches sharing a bus, no address is ever Modified in two caches at once.
- R12: A snoop whose tag does not match, or whose kind is write-back, asserts no response and changes no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_req_valid | input | 1 | Local request present |
| cpu_req_write | input | 1 | 1 = write, 0 = read |
| cpu_req_addr | input | ADDR_W | Local line address (low IDX_W bits are the index) |
| cpu_ack | output | 1 | Local request completes this cycle |
| cpu_line_state | output | 2 | State held for `cpu_req_addr` (I if tag differs) |
| bus_req_valid | output | 1 | Bus transaction requested |
| bus_req_kind | output | 2 | 0 read, 1 intent-to-write, 2 write-back |
| bus_req_addr | output | ADDR_W | Address of the requested transaction |
| bus_grant | input | 1 | Requested transaction is on the bus this cycle |
| bus_shared_in | input | 1 | Another cache reports holding the line |
| snp_valid | input | 1 | Another cache's transaction is on the bus |
| snp_kind | input | 2 | Kind of the snooped transaction |
| snp_addr | input | ADDR_W | Address of the snooped transaction |
| snp_shared | output | 1 | This cache holds a valid copy of the snooped line |
| snp_wb | output | 1 | This cache holds the snooped line dirty and supplies it |

## Verification
A wrong stored state shows at the ports by the next access to that line. A stale copy appears as a read hit with no bus request where a miss was expected. A lost dirty line appears as a missing `snp_wb` when another cache reads or claims it. A wrong fill choice appears as a later silent write where an intent-to-write should have appeared. Two caches are run on a shared bus, and `cpu_line_state` is probed in both after every operation, so an illegal pair of states is caught in the cycle right after the transaction that caused it.

// File: rtl/mesi_pkg.sv
package mesi_pkg;
    typedef enum logic [1:0] {
        ST_I = 2'd0,
        ST_S = 2'd1,
        ST_E = 2'd2,
        ST_M = 2'd3
    } line_st_e;

    typedef enum logic [1:0] {
        BK_RD  = 2'd0,
        BK_ITW = 2'd1,
        BK_WB  = 2'd2
    } bus_kind_e;
endpackage

// File: rtl/mesi_tag_array.sv
module mesi_tag_array
    import mesi_pkg::*;
#(
    parameter int IDX_W = 3,
    parameter int TAG_W = 13
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IDX_W-1:0] rd_a_idx,
    output logic [TAG_W-1:0] rd_a_tag,
    output line_st_e         rd_a_st,
    input  logic [IDX_W-1:0] rd_b_idx,
    output logic [TAG_W-1:0] rd_b_tag,
    output line_st_e         rd_b_st,
    input  logic             wr_l_en,
    input  logic [IDX_W-1:0] wr_l_idx,
    input  logic [TAG_W-1:0] wr_l_tag,
    input  line_st_e         wr_l_st,
    input  logic             wr_s_en,
    input  logic [IDX_W-1:0] wr_s_idx,
    input  line_st_e         wr_s_st
);
    localparam int LINES = 1 << IDX_W;

    typedef struct packed {
        logic [TAG_W-1:0] tag;
        line_st_e         st;
    } entry_t;

    entry_t mem_q [LINES];
    entry_t mem_d [LINES];

    always_comb begin
        mem_d = mem_q;
        if (wr_l_en) begin
            mem_d[wr_l_idx].tag = wr_l_tag;
            mem_d[wr_l_idx].st  = wr_l_st;
        end
        // snoop update applied last: it wins on a shared index
        if (wr_s_en) begin
            mem_d[wr_s_idx].st = wr_s_st;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < LINES; i++) begin
                mem_q[i] <= '{tag: '0, st: ST_I};
            end
        end else begin
            mem_q <= mem_d;
        end
    end

    assign rd_a_tag = mem_q[rd_a_idx].tag;
    assign rd_a_st  = mem_q[rd_a_idx].st;
    assign rd_b_tag = mem_q[rd_b_idx].tag;
    assign rd_b_st  = mem_q[rd_b_idx].st;
endmodule

// File: rtl/mesi_snoop_unit.sv
module mesi_snoop_unit
    import mesi_pkg::*;
#(
    parameter int TAG_W = 13
) (
    input  logic             snp_valid,
    input  bus_kind_e        snp_kind,
    input  logic [TAG_W-1:0] snp_tag,
    input  logic [TAG_W-1:0] line_tag,
    input  line_st_e         line_st,
    output logic             hit_shared,
    output logic             dirty_wb,
    output logic             upd_en,
    output line_st_e         upd_st
);
    logic holds;

    always_comb begin
        holds      = snp_valid && (snp_tag == line_tag) && (line_st != ST_I);
        hit_shared = holds && (snp_kind != BK_WB);
        dirty_wb   = hit_shared && (line_st == ST_M);
        upd_en     = hit_shared;
        upd_st     = (snp_kind == BK_ITW) ? ST_I : ST_S;
    end
endmodule

// File: rtl/mesi_local_unit.sv
module mesi_local_unit
    import mesi_pkg::*;
#(
    parameter int TAG_W = 13
) (
    input  logic             req_valid,
    input  logic             req_write,
    input  logic [TAG_W-1:0] req_tag,
    input  logic [TAG_W-1:0] line_tag,
    input  line_st_e         line_st,
    input  logic             bus_grant,
    input  logic             bus_shared_in,
    input  logic             snoop_block,
    output logic             ack,
    output logic             breq_valid,
    output bus_kind_e        breq_kind,
    output logic             breq_victim,
    output logic             upd_en,
    output logic [TAG_W-1:0] upd_tag,
    output line_st_e         upd_st
);
    logic hit;
    logic owned;

    always_comb begin
        ack         = 1'b0;
        breq_valid  = 1'b0;
        breq_kind   = BK_RD;
        breq_victim = 1'b0;
        upd_en      = 1'b0;
        upd_tag     = req_tag;
        upd_st      = ST_I;
        hit         = (line_tag == req_tag) && (line_st != ST_I);
        owned       = (line_st == ST_E) || (line_st == ST_M);
        if (req_valid) begin
            if (hit && (!req_write || owned)) begin
                ack    = !snoop_block;
                upd_en = req_write && !snoop_block;
                upd_st = ST_M;
            end else if (!hit && line_st == ST_M) begin
                breq_valid  = 1'b1;
                breq_kind   = BK_WB;
                breq_victim = 1'b1;
                if (bus_grant) begin
                    upd_en  = 1'b1;
                    upd_tag = line_tag;
                    upd_st  = ST_I;
                end
            end else begin
                breq_valid = 1'b1;
                breq_kind  = req_write ? BK_ITW : BK_RD;
                if (bus_grant) begin
                    ack    = 1'b1;
                    upd_en = 1'b1;
                    if (req_write)          upd_st = ST_M;
                    else if (bus_shared_in) upd_st = ST_S;
                    else                    upd_st = ST_E;
                end
            end
        end
    end
endmodule

// File: rtl/mesi_line_ctrl.sv
module mesi_line_ctrl
    import mesi_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int IDX_W  = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cpu_req_valid,
    input  logic              cpu_req_write,
    input  logic [ADDR_W-1:0] cpu_req_addr,
    output logic              cpu_ack,
    output logic [1:0]        cpu_line_state,
    output logic              bus_req_valid,
    output logic [1:0]        bus_req_kind,
    output logic [ADDR_W-1:0] bus_req_addr,
    input  logic              bus_grant,
    input  logic              bus_shared_in,
    input  logic              snp_valid,
    input  logic [1:0]        snp_kind,
    input  logic [ADDR_W-1:0] snp_addr,
    output logic              snp_shared,
    output logic              snp_wb
);
    localparam int TAG_W = ADDR_W - IDX_W;

    logic [IDX_W-1:0] cpu_idx, snp_idx;
    logic [TAG_W-1:0] cpu_tag, snp_tag;
    logic [TAG_W-1:0] a_tag, b_tag, l_tag;
    line_st_e         a_st, b_st, l_st, s_st;
    logic             l_en, s_en, victim, block;
    bus_kind_e        kind;

    assign cpu_idx = cpu_req_addr[IDX_W-1:0];
    assign cpu_tag = cpu_req_addr[ADDR_W-1:IDX_W];
    assign snp_idx = snp_addr[IDX_W-1:0];
    assign snp_tag = snp_addr[ADDR_W-1:IDX_W];
    assign block   = snp_valid && (snp_idx == cpu_idx);

    mesi_tag_array #(.IDX_W(IDX_W), .TAG_W(TAG_W)) u_arr (
        .clk(clk), .rst_n(rst_n),
        .rd_a_idx(cpu_idx), .rd_a_tag(a_tag), .rd_a_st(a_st),
        .rd_b_idx(snp_idx), .rd_b_tag(b_tag), .rd_b_st(b_st),
        .wr_l_en(l_en), .wr_l_idx(cpu_idx), .wr_l_tag(l_tag), .wr_l_st(l_st),
        .wr_s_en(s_en), .wr_s_idx(snp_idx), .wr_s_st(s_st)
    );

    mesi_snoop_unit #(.TAG_W(TAG_W)) u_snp (
        .snp_valid(snp_valid), .snp_kind(bus_kind_e'(snp_kind)),
        .snp_tag(snp_tag), .line_tag(b_tag), .line_st(b_st),
        .hit_shared(snp_shared), .dirty_wb(snp_wb),
        .upd_en(s_en), .upd_st(s_st)
    );

    mesi_local_unit #(.TAG_W(TAG_W)) u_loc (
        .req_valid(cpu_req_valid), .req_write(cpu_req_write),
        .req_tag(cpu_tag), .line_tag(a_tag), .line_st(a_st),
        .bus_grant(bus_grant), .bus_shared_in(bus_shared_in),
        .snoop_block(block),
        .ack(cpu_ack), .breq_valid(bus_req_valid), .breq_kind(kind),
        .breq_victim(victim), .upd_en(l_en), .upd_tag(l_tag), .upd_st(l_st)
    );

    assign bus_req_kind   = kind;
    assign bus_req_addr   = victim ? {a_tag, cpu_idx} : cpu_req_addr;
    assign cpu_line_state = (a_tag == cpu_tag) ? a_st : ST_I;
endmodule

// File: rtl/mesi_line_ctrl_chk.sv
module mesi_line_ctrl_chk #(
    parameter int ADDR_W = 16,
    parameter int IDX_W  = 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cpu_req_valid,
    input logic              cpu_req_write,
    input logic [ADDR_W-1:0] cpu_req_addr,
    input logic              cpu_ack,
    input logic [1:0]        cpu_line_state,
    input logic              bus_req_valid,
    input logic [1:0]        bus_req_kind,
    input logic [ADDR_W-1:0] bus_req_addr,
    input logic              snp_valid,
    input logic [1:0]        snp_kind,
    input logic [ADDR_W-1:0] snp_addr,
    input logic              snp_shared,
    input logic              snp_wb
);
    logic same_idx;
    assign same_idx = snp_valid && (snp_addr[IDX_W-1:0] == cpu_req_addr[IDX_W-1:0]);

    a_r2_read_fill: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_ack && !cpu_req_write |=>
            (!$stable(cpu_req_addr) || snp_valid || cpu_line_state != 2'd0));

    a_r3_silent_write: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_req_valid && cpu_req_write && cpu_line_state[1] && !same_idx |->
            cpu_ack && !bus_req_valid);

    a_r4_write_ends_modified: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_ack && cpu_req_write |=>
            (!$stable(cpu_req_addr) || snp_valid || cpu_line_state == 2'd3));

    a_r5_shared_upgrade: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_req_valid && cpu_req_write && cpu_line_state == 2'd1 |->
            bus_req_valid && bus_req_kind == 2'd1);

    a_r6_wb_needs_copy: assert property (@(posedge clk) disable iff (!rst_n)
        snp_wb |-> snp_shared && snp_valid);

    a_r9_snoop_priority: assert property (@(posedge clk) disable iff (!rst_n)
        same_idx && !bus_req_valid |-> !cpu_ack);

    a_r10_victim_addr: assert property (@(posedge clk) disable iff (!rst_n)
        bus_req_valid && bus_req_kind == 2'd2 |->
            bus_req_addr[IDX_W-1:0] == cpu_req_addr[IDX_W-1:0] &&
            bus_req_addr != cpu_req_addr);

    a_r12_wb_snoop_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        snp_kind == 2'd2 |-> !snp_shared && !snp_wb);
endmodule

bind mesi_line_ctrl mesi_line_ctrl_chk #(.ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_chk (
    .clk(clk), .rst_n(rst_n),
    .cpu_req_valid(cpu_req_valid), .cpu_req_write(cpu_req_write),
    .cpu_req_addr(cpu_req_addr), .cpu_ack(cpu_ack),
    .cpu_line_state(cpu_line_state),
    .bus_req_valid(bus_req_valid), .bus_req_kind(bus_req_kind),
    .bus_req_addr(bus_req_addr),
    .snp_valid(snp_valid), .snp_kind(snp_kind), .snp_addr(snp_addr),
    .snp_shared(snp_shared), .snp_wb(snp_wb)
);

// File: tb/sim_mesi_line_ctrl.sv
`timescale 1ns/1ps
module sim_mesi_line_ctrl;
    localparam int AW = 16;
    localparam logic [1:0] I = 2'd0, S = 2'd1, E = 2'd2, M = 2'd3;
    localparam logic [AW-1:0] A = 16'h0010, B = 16'h0018, C = 16'h0021, D = 16'h0029;

    logic clk = 1'b0;
    logic rst_n;
    always #2 clk = ~clk;

    logic          cv [2];
    logic          cw [2];
    logic [AW-1:0] ca [2];
    logic          ack [2];
    logic [1:0]    ls [2];
    logic          breq [2];
    logic [1:0]    bkind [2];
    logic [AW-1:0] baddr [2];
    logic          sshr [2];
    logic          swb [2];
    logic          g0, g1;

    assign g0 = breq[0];
    assign g1 = breq[1] && !breq[0];

    mesi_line_ctrl #(.ADDR_W(AW), .IDX_W(3)) u0 (
        .clk(clk), .rst_n(rst_n),
        .cpu_req_valid(cv[0]), .cpu_req_write(cw[0]), .cpu_req_addr(ca[0]),
        .cpu_ack(ack[0]), .cpu_line_state(ls[0]),
        .bus_req_valid(breq[0]), .bus_req_kind(bkind[0]), .bus_req_addr(baddr[0]),
        .bus_grant(g0), .bus_shared_in(sshr[1]),
        .snp_valid(g1), .snp_kind(bkind[1]), .snp_addr(baddr[1]),
        .snp_shared(sshr[0]), .snp_wb(swb[0])
    );

    mesi_line_ctrl #(.ADDR_W(AW), .IDX_W(3)) u1 (
        .clk(clk), .rst_n(rst_n),
        .cpu_req_valid(cv[1]), .cpu_req_write(cw[1]), .cpu_req_addr(ca[1]),
        .cpu_ack(ack[1]), .cpu_line_state(ls[1]),
        .bus_req_valid(breq[1]), .bus_req_kind(bkind[1]), .bus_req_addr(baddr[1]),
        .bus_grant(g1), .bus_shared_in(sshr[0]),
        .snp_valid(g0), .snp_kind(bkind[0]), .snp_addr(baddr[0]),
        .snp_shared(sshr[1]), .snp_wb(swb[1])
    );

    int checks = 0;
    int errors = 0;

    task automatic chk(input bit ok, input string req, input logic [31:0] got,
                       input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s got=%0h exp=%0h", req, got, exp);
        end
    endtask

    // mask bit0 = read, bit1 = intent-to-write, bit2 = write-back
    typedef struct packed {
        logic          who;
        logic          wr;
        logic [AW-1:0] addr;
        logic [1:0]    e0;
        logic [1:0]    e1;
        logic [2:0]    mask;
        logic          wb;
    } vec_t;

    localparam vec_t VEC [13] = '{
        '{1'b0, 1'b0, A, E, I, 3'b001, 1'b0},  // R2 fill exclusive
        '{1'b0, 1'b1, A, M, I, 3'b000, 1'b0},  // R3 silent upgrade
        '{1'b1, 1'b0, A, S, S, 3'b001, 1'b1},  // R6 dirty snooped read
        '{1'b1, 1'b1, A, I, M, 3'b010, 1'b0},  // R5 R8 shared upgrade
        '{1'b0, 1'b1, A, M, I, 3'b010, 1'b1},  // R4 R8 write miss on dirty peer
        '{1'b0, 1'b0, B, E, I, 3'b101, 1'b0},  // R10 victim write-back
        '{1'b1, 1'b0, B, S, S, 3'b001, 1'b0},  // R7 exclusive to shared
        '{1'b1, 1'b0, C, I, E, 3'b001, 1'b0},  // R2
        '{1'b0, 1'b0, C, S, S, 3'b001, 1'b0},  // R2 R7 shared fill
        '{1'b1, 1'b0, C, S, S, 3'b000, 1'b0},  // R3 read hit in S
        '{1'b0, 1'b1, C, M, I, 3'b010, 1'b0},  // R5
        '{1'b0, 1'b0, C, M, I, 3'b000, 1'b0},  // R3 read hit in M
        '{1'b1, 1'b0, D, I, E, 3'b001, 1'b0}   // R12 tag mismatch snoop
    };

    task automatic probe(input logic [AW-1:0] a, output logic [1:0] s0,
                         output logic [1:0] s1);
        cv[0] = 1'b0; cv[1] = 1'b0;
        ca[0] = a;    ca[1] = a;
        #1;
        s0 = ls[0];
        s1 = ls[1];
    endtask

    task automatic run_op(input int who, input logic wr, input logic [AW-1:0] a,
                          output logic [2:0] mask, output logic wbseen,
                          output bit done);
        mask = '0; wbseen = 1'b0; done = 1'b0;
        cv[who] = 1'b1; cw[who] = wr; ca[who] = a;
        for (int n = 0; n < 20; n++) begin
            #1;
            if ((who == 0 && g0) || (who == 1 && g1)) mask[bkind[who]] = 1'b1;
            if (swb[1-who]) wbseen = 1'b1;
            if (ack[who]) done = 1'b1;
            @(negedge clk);
            if (done) break;
        end
        cv[who] = 1'b0;
    endtask

    task automatic no_double_m(input logic [1:0] s0, input logic [1:0] s1);
        chk(!(s0 == M && s1 == M), "R11 no double Modified", {s0, s1}, 32'h0);
    endtask

    initial begin
        #400000;
        errors++; checks++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        logic [1:0] s0, s1;
        logic [2:0] mask;
        logic       wbs;
        bit         done;
        rst_n = 1'b0;
        for (int k = 0; k < 2; k++) begin
            cv[k] = 1'b0; cw[k] = 1'b0; ca[k] = '0;
        end
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state
        probe(A, s0, s1);
        chk(s0 == I && s1 == I, "R1 reset A", {s0, s1}, 32'h0);
        probe(16'hFFFF, s0, s1);
        chk(s0 == I && s1 == I, "R1 reset FFFF", {s0, s1}, 32'h0);
        chk(!breq[0] && !breq[1] && !ack[0] && !ack[1], "R1 idle outputs",
            {breq[0], breq[1], ack[0], ack[1]}, 32'h0);
        @(negedge clk);

        foreach (VEC[i]) begin
            run_op(int'(VEC[i].who), VEC[i].wr, VEC[i].addr, mask, wbs, done);
            chk(done, $sformatf("vec%0d ack", i), done, 1);
            chk(mask == VEC[i].mask, $sformatf("vec%0d bus kinds R2 R4 R5 R10", i),
                mask, VEC[i].mask);
            chk(wbs == VEC[i].wb, $sformatf("vec%0d peer wb R6 R8", i), wbs, VEC[i].wb);
            probe(VEC[i].addr, s0, s1);
            chk(s0 == VEC[i].e0, $sformatf("vec%0d cache0 state", i), s0, VEC[i].e0);
            chk(s1 == VEC[i].e1, $sformatf("vec%0d cache1 state", i), s1, VEC[i].e1);
            no_double_m(s0, s1);
            @(negedge clk);
        end

        // R12: mismatching snoop left cache0's dirty C untouched
        probe(C, s0, s1);
        chk(s0 == M, "R12 mismatch snoop kept C", s0, M);
        // R10: evicted line A gone from cache0
        probe(A, s0, s1);
        chk(s0 == I && s1 == I, "R10 victim A invalid", {s0, s1}, 32'h0);
        @(negedge clk);

        // R9: cache0 upgrades B while cache1 tries a read hit on B
        cv[0] = 1'b1; cw[0] = 1'b1; ca[0] = B;
        cv[1] = 1'b1; cw[1] = 1'b0; ca[1] = B;
        #1;
        chk(ack[0] == 1'b1, "R9 bus owner completes", ack[0], 1);
        chk(ack[1] == 1'b0, "R9 snooped index blocks local hit", ack[1], 0);
        @(negedge clk);
        cv[0] = 1'b0;
        run_op(1, 1'b0, B, mask, wbs, done);
        chk(done && mask == 3'b001, "R9 retry becomes read miss", {done, mask}, 32'h9);
        chk(wbs, "R6 peer supplied dirty B", wbs, 1);
        probe(B, s0, s1);
        chk(s0 == S && s1 == S, "R6 R9 B shared in both", {s0, s1}, {S, S});
        no_double_m(s0, s1);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule